// File: doc/BRIEF.md
# Three-Counter Performance Monitor

This block counts activity inside a processor core. It holds one free-running cycle counter and two event counters, all 32 bits wide. Each event counter has an 8-bit selector that picks one of the core's event pulse inputs. One packed control word holds the master run bit, the counter clear requests, the cycle divider choice, the per-counter interrupt enables, the sticky wrap flags and both event selectors. A single interrupt line goes high while any counter has both its wrap flag and its enable set.

Software reaches the block through a small register port with four word locations. It can program the control word and can read or overwrite any counter. The event counters have no enable of their own. To stop one, software selects a code that never fires. The cycle counter cannot be halted by itself; software can only mask its interrupt. The wrap flags are cleared by writing 1 to them. Because of this, writing back a control value just read clears only the flags that were set in that value and leaves every other field as it was.

Top module: `perf_mon3`

## Requirements
- R1: After reset the control word, all three counters and `irq` read as zero.
- R2: The register port decodes `reg_addr` 0 as the control word, 1 as the cycle counter, 2 as event counter A and 3 as event counter B. A write at 1, 2 or 3 loads that counter directly, and `reg_rdata` returns the addressed location combinationally.
- R3: Event counter A's selector sits in control bits 27:20 and event counter B's in bits 19:12. A selector value k in 0x00 to 0x12 adds one at each clock edge where `evt_in[k]` is high. A pulse that drives both selected inputs at once advances both counters.
- R4: Selector values above 0x12, including 0x20, never advance an event counter, even with every event input high.
- R5: Control bit 0 is the master run bit. While it is 0, no counter advances.
- R6: While bit 0 is 1, the cycle counter adds one at every edge when control bit 3 is 0. When bit 3 is 1 it adds one on every 64th edge, and the first advance comes on the 64th edge after bit 3 is set.
- R7: When a counter wraps from all ones to zero, its sticky flag is set: bit 8 for event counter A, bit 9 for B, bit 10 for the cycle counter.
- R8: `irq` is high exactly while some counter has both its wrap flag and its interrupt enable set. The enables are bit 4 (A), bit 5 (B) and bit 6 (cycle). A flag with its enable clear still reads back but does not raise `irq`.
- R9: Writing 1 to a flag bit clears it. Writing back a value just read leaves every read/write field unchanged.
- R10: If a wrap and a clear of the same flag fall in the same cycle, the flag ends up set.
- R11: Control bit 1 clears both event counters and bit 2 clears the cycle counter. Each acts on the edge after the control write and always reads back as 0.
- R12: If a pending counter clear and a direct write to that counter take effect at the same edge, the written value is kept.
- R13: Control bits 7, 11 and 31:28 are unassigned and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Word location: 0 control, 1 cycle, 2 event A, 3 event B |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_in | input | 19 | Core event pulses, one bit per event code |
| irq | output | 1 | Combined counter interrupt |

## Verification
The case of interest is a counter wrap that lands on the same edge as a control write clearing that counter's flag. The bench preloads event counter B with all ones. It then drives the control write with bit 9 set and `evt_in[7]` high in the same cycle, and expects bit 9 to read back set, the counter to read zero and `irq` to stay high. A second collision writes event counter A directly on the edge where a clear requested one cycle earlier takes effect. The bench expects the written value on A and zero on B.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

   // Width of the register port and of the packed control word.
   localparam int REG_W    = 32;
   // Selector width; the control layout reserves 8 bits per selector.
   localparam int SEL_W    = 8;
   // Two event counters plus the cycle counter.
   localparam int NUM_EV   = 2;
   localparam int NUM_CTR  = NUM_EV + 1;

   // Control word bit positions. Flags and enables share the order
   // {cycle, event B, event A} so they can be handled as vectors.
   localparam int B_RUN      = 0;
   localparam int B_CLR_EV   = 1;
   localparam int B_CLR_CY   = 2;
   localparam int B_DIV      = 3;
   localparam int B_IEN_LO   = 4;
   localparam int B_FLAG_LO  = 8;
   localparam int B_SELB_LO  = 12;
   localparam int B_SELA_LO  = 20;

   typedef enum logic [1:0] {
      LOC_CTRL = 2'd0,
      LOC_CYC  = 2'd1,
      LOC_EVA  = 2'd2,
      LOC_EVB  = 2'd3
   } pm_loc_e;

   // Selector base bit for event counter idx.
   function automatic int sel_base(input int idx);
      return (idx == 0) ? B_SELA_LO : B_SELB_LO;
   endfunction

   // Register location of event counter idx.
   function automatic logic [1:0] ev_loc(input int idx);
      return (idx == 0) ? LOC_EVA : LOC_EVB;
   endfunction

endpackage

// File: rtl/pm_evt_select.sv
module pm_evt_select #(
   parameter int NUM_EVT = 19,
   parameter int SW      = 8
) (
   input  logic [SW-1:0]      sel,
   input  logic [NUM_EVT-1:0] evt,
   output logic               hit
);

   localparam int CODES = 1 << SW;

   initial begin
      a_prm_codes_fit : assert (NUM_EVT >= 1 && NUM_EVT <= CODES)
         else $error("event count does not fit the selector width");
   end

   // Decode every implemented code explicitly. Codes at or beyond
   // NUM_EVT match no term and yield no hit.
   always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NUM_EVT; k++) begin
         if (sel == SW'(k)) hit = evt[k];
      end
   end

endmodule

// File: rtl/pm_prescaler.sv
module pm_prescaler #(
   parameter int LOG2 = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   initial begin
      a_prm_log2 : assert (LOG2 >= 0 && LOG2 <= 16)
         else $error("prescaler width out of range");
   end

   generate
      if (LOG2 == 0) begin : g_bypass
         assign tick = run;
      end else begin : g_div
         logic [LOG2-1:0] psc;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   psc <= '0;
            else if (run) psc <= psc + 1'b1;
            else          psc <= '0;
         end

         assign tick = run & (&psc);

         // R6: consecutive divided ticks are never adjacent
         a_r6_tick_spacing : assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   initial begin
      a_prm_width : assert (W >= 2)
         else $error("counter width too small");
   end

   // Priority: direct write, then clear, then increment.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (wr_en) cnt <= wr_data;
      else if (clr)   cnt <= '0;
      else if (inc)   cnt <= cnt + 1'b1;
   end

   assign wrap = inc & ~wr_en & ~clr & (&cnt);

   // R12: a direct write wins over everything else at its edge
   a_r12_write_wins : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cnt == $past(wr_data));

   // R11: a clear request without a write leaves zero
   a_r11_clear_zeroes : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !wr_en) |=> cnt == '0);

endmodule

// File: rtl/perf_mon3.sv
module perf_mon3
   import perfmon_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int NUM_EVT  = 19,
   parameter int PSC_LOG2 = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [1:0]         reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic [NUM_EVT-1:0] evt_in,
   output logic               irq
);

   initial begin
      a_prm_cnt_w : assert (CNT_W >= 2 && CNT_W <= REG_W)
         else $error("counter width must fit the register port");
      a_prm_evt : assert (NUM_EVT >= 1 && NUM_EVT <= (1 << SEL_W))
         else $error("event count exceeds selector range");
   end

   // ------------------------------------------------------------------
   // Register port decode
   // ------------------------------------------------------------------
   logic ctrl_wr;
   logic cy_wr;
   logic [NUM_EV-1:0] ev_wr;

   assign ctrl_wr = reg_wr && (reg_addr == LOC_CTRL);
   assign cy_wr   = reg_wr && (reg_addr == LOC_CYC);

   // ------------------------------------------------------------------
   // Control state
   // ------------------------------------------------------------------
   logic                          run_q;
   logic                          div_q;
   logic [NUM_CTR-1:0]            ien_q;
   logic [NUM_CTR-1:0]            flag_q;
   logic [NUM_EV-1:0][SEL_W-1:0]  sel_q;
   logic                          clr_ev_q;
   logic                          clr_cy_q;
   logic [NUM_CTR-1:0]            wrap_v;
   logic [NUM_CTR-1:0]            flag_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         div_q <= 1'b0;
         ien_q <= '0;
         sel_q <= '0;
      end else if (ctrl_wr) begin
         run_q <= reg_wdata[B_RUN];
         div_q <= reg_wdata[B_DIV];
         ien_q <= reg_wdata[B_IEN_LO +: NUM_CTR];
         for (int i = 0; i < NUM_EV; i++) begin
            sel_q[i] <= reg_wdata[sel_base(i) +: SEL_W];
         end
      end
   end

   // Clear requests live for exactly one cycle after the control write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_ev_q <= 1'b0;
         clr_cy_q <= 1'b0;
      end else begin
         clr_ev_q <= ctrl_wr & reg_wdata[B_CLR_EV];
         clr_cy_q <= ctrl_wr & reg_wdata[B_CLR_CY];
      end
   end

   // Sticky flags: write-1-to-clear, with a same-cycle wrap taking priority.
   assign flag_clr = ctrl_wr ? reg_wdata[B_FLAG_LO +: NUM_CTR] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~flag_clr) | wrap_v;
   end

   assign irq = |(flag_q & ien_q);

   // ------------------------------------------------------------------
   // Event counters
   // ------------------------------------------------------------------
   logic [CNT_W-1:0]  ev_cnt [NUM_EV];
   logic [NUM_EV-1:0] ev_hit;
   logic [NUM_EV-1:0] ev_inc;
   logic [NUM_EV-1:0] ev_wrap;

   generate
      for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
         assign ev_wr[i] = reg_wr && (reg_addr == ev_loc(i));

         pm_evt_select #(
            .NUM_EVT (NUM_EVT),
            .SW      (SEL_W)
         ) u_sel (
            .sel (sel_q[i]),
            .evt (evt_in),
            .hit (ev_hit[i])
         );

         assign ev_inc[i] = run_q & ev_hit[i];

         pm_counter #(
            .W (CNT_W)
         ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ev_wr[i]),
            .wr_data (reg_wdata[CNT_W-1:0]),
            .clr     (clr_ev_q),
            .inc     (ev_inc[i]),
            .cnt     (ev_cnt[i]),
            .wrap    (ev_wrap[i])
         );

         // R5: nothing moves an event counter while the run bit is low
         a_r5_idle_when_off : assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q && !ev_wr[i] && !clr_ev_q) |=> $stable(ev_cnt[i]));

         // R4: unimplemented selector codes never count
         a_r4_bad_code_silent : assert property (@(posedge clk) disable iff (!rst_n)
            (int'(sel_q[i]) >= NUM_EVT && !ev_wr[i] && !clr_ev_q) |=> $stable(ev_cnt[i]));
      end
   endgenerate

   // ------------------------------------------------------------------
   // Cycle counter with optional prescaler
   // ------------------------------------------------------------------
   logic [CNT_W-1:0] cy_cnt;
   logic             psc_tick;
   logic             cy_inc;
   logic             cy_wrap;

   pm_prescaler #(
      .LOG2 (PSC_LOG2)
   ) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q & div_q),
      .tick  (psc_tick)
   );

   assign cy_inc = run_q & (div_q ? psc_tick : 1'b1);

   pm_counter #(
      .W (CNT_W)
   ) u_cyc (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cy_wr),
      .wr_data (reg_wdata[CNT_W-1:0]),
      .clr     (clr_cy_q),
      .inc     (cy_inc),
      .cnt     (cy_cnt),
      .wrap    (cy_wrap)
   );

   assign wrap_v = {cy_wrap, ev_wrap};

   // ------------------------------------------------------------------
   // Read path
   // ------------------------------------------------------------------
   logic [REG_W-1:0] ctrl_word;

   always_comb begin
      ctrl_word                         = '0;
      ctrl_word[B_RUN]                  = run_q;
      ctrl_word[B_DIV]                  = div_q;
      ctrl_word[B_IEN_LO +: NUM_CTR]    = ien_q;
      ctrl_word[B_FLAG_LO +: NUM_CTR]   = flag_q;
      for (int i = 0; i < NUM_EV; i++) begin
         ctrl_word[sel_base(i) +: SEL_W] = sel_q[i];
      end
   end

   always_comb begin
      unique case (reg_addr)
         LOC_CTRL: reg_rdata = ctrl_word;
         LOC_CYC:  reg_rdata = REG_W'(cy_cnt);
         LOC_EVA:  reg_rdata = REG_W'(ev_cnt[0]);
         default:  reg_rdata = REG_W'(ev_cnt[1]);
      endcase
   end

   // ------------------------------------------------------------------
   // Assertions
   // ------------------------------------------------------------------
   // R7: a cycle-counter wrap leaves its flag set
   a_r7_wrap_sets_flag : assert property (@(posedge clk) disable iff (!rst_n)
      (cy_inc && (&cy_cnt) && !cy_wr && !clr_cy_q) |=> flag_q[NUM_CTR-1]);

   // R10: any wrap leaves its flag set even under a same-cycle clear
   a_r10_set_beats_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (|wrap_v) |=> (flag_q & $past(wrap_v)) == $past(wrap_v));

   // R8: the interrupt only drops after a control write
   a_r8_irq_drop_needs_write : assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ctrl_wr) |=> irq);

   // R9: read/write fields follow the control write
   a_r9_fields_follow_write : assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (run_q == $past(reg_wdata[B_RUN])) &&
                  (ien_q == $past(reg_wdata[B_IEN_LO +: NUM_CTR])));

   // R13: unassigned control bits read as zero
   a_r13_spare_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[7] == 1'b0) && (ctrl_word[11] == 1'b0) && (ctrl_word[31:28] == 4'h0));

endmodule

// File: tb/sim_perf_mon3.sv
`timescale 1ns/1ps
module sim_perf_mon3;

   localparam int NE = 19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NE-1:0] evt_in = '0;
   logic          irq;

   always #2 clk = ~clk;

   perf_mon3 u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_in    (evt_in),
      .irq       (irq)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   event     smp_ev;
   int       n_cmp = 0;
   int       n_bad = 0;
   bit       done  = 1'b0;

   // Monitor: pops the expected item and compares against the outputs.
   initial begin
      forever begin
         @(smp_ev);
         #0.2;
         if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq} : reg_rdata;
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #0.5;
      reg_wr = 1'b0;
   endtask

   task automatic pulse(input logic [NE-1:0] v);
      @(negedge clk);
      evt_in = v;
      @(posedge clk);
      #0.5;
      evt_in = '0;
   endtask

   task automatic idle(input int k);
      repeat (k) @(posedge clk);
   endtask

   task automatic chk_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
      sb_item_t it;
      @(negedge clk);
      reg_addr = a;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      -> smp_ev;
      #0.5;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      sb_item_t it;
      @(negedge clk);
      it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
      sb_q.push_back(it);
      -> smp_ev;
      #0.5;
   endtask

   function automatic logic [NE-1:0] ev(input int k);
      return NE'(1) << k;
   endfunction

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         report();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_rd(2'd0, 32'h0, "R1 ctrl after reset");
      chk_rd(2'd1, 32'h0, "R1 cycle after reset");
      chk_rd(2'd2, 32'h0, "R1 event A after reset");
      chk_rd(2'd3, 32'h0, "R1 event B after reset");
      chk_irq(1'b0, "R1 irq after reset");

      // R2 direct loads and address decode
      wr(2'd1, 32'hDEADBEEF);
      wr(2'd2, 32'h13579BDF);
      wr(2'd3, 32'h2468ACE0);
      chk_rd(2'd1, 32'hDEADBEEF, "R2 cycle load");
      chk_rd(2'd2, 32'h13579BDF, "R2 event A load");
      chk_rd(2'd3, 32'h2468ACE0, "R2 event B load");

      // R6 cycle counting, undivided: K idle gives K+1 counts
      wr(2'd1, 32'h0);
      wr(2'd0, 32'h1);
      idle(9);
      wr(2'd0, 32'h0);
      chk_rd(2'd1, 32'd10, "R6 cycle undivided");

      // R6 divided: 63 edges give nothing, 64 give one, 130 give two
      wr(2'd1, 32'h0);
      wr(2'd0, 32'h9);
      idle(62);
      wr(2'd0, 32'h0);
      chk_rd(2'd1, 32'd0, "R6 divided 63 edges");
      wr(2'd1, 32'h0);
      wr(2'd0, 32'h9);
      idle(63);
      wr(2'd0, 32'h0);
      chk_rd(2'd1, 32'd1, "R6 divided 64 edges");
      wr(2'd1, 32'h0);
      wr(2'd0, 32'h9);
      idle(129);
      wr(2'd0, 32'h0);
      chk_rd(2'd1, 32'd2, "R6 divided 130 edges");

      // R3 event selection: A on code 5, B on code 0x12
      wr(2'd2, 32'h0);
      wr(2'd3, 32'h0);
      wr(2'd0, 32'h00512001);
      chk_rd(2'd0, 32'h00512001, "R3 selector readback");
      for (int k = 0; k < 3; k++) pulse(ev(5));
      for (int k = 0; k < 2; k++) pulse(ev(18));
      pulse(ev(5) | ev(18));
      pulse(ev(9));
      wr(2'd0, 32'h00512000);
      chk_rd(2'd2, 32'd4, "R3 event A count");
      chk_rd(2'd3, 32'd3, "R3 event B count at top code");

      // R5 run bit low: pulses ignored
      pulse(ev(5));
      pulse(ev(18) | ev(5));
      chk_rd(2'd2, 32'd4, "R5 event A held");
      chk_rd(2'd3, 32'd3, "R5 event B held");

      // R4 stop codes 0x20 and 0x13
      wr(2'd2, 32'h10);
      wr(2'd0, 32'h02000001);
      for (int k = 0; k < 3; k++) pulse('1);
      wr(2'd0, 32'h01300001);
      for (int k = 0; k < 2; k++) pulse('1);
      wr(2'd0, 32'h0);
      chk_rd(2'd2, 32'h10, "R4 stop codes do not count");

      // R7 / R8 wrap of event A with enable
      wr(2'd2, 32'hFFFFFFFE);
      wr(2'd0, 32'h00500011);
      pulse(ev(5));
      pulse(ev(5));
      wr(2'd0, 32'h00500010);
      chk_rd(2'd2, 32'h0, "R7 event A wrapped");
      chk_rd(2'd0, 32'h00500110, "R7 flag A set");
      chk_irq(1'b1, "R8 irq with enable");

      // R9 write-back clears only the flag
      wr(2'd0, 32'h00500110);
      chk_rd(2'd0, 32'h00500010, "R9 write-back");
      chk_irq(1'b0, "R9 irq after clear");

      // R8 flag without enable
      wr(2'd3, 32'hFFFFFFFF);
      wr(2'd0, 32'h00007001);
      pulse(ev(7));
      wr(2'd0, 32'h00007000);
      chk_rd(2'd0, 32'h00007200, "R8 flag B without enable");
      chk_irq(1'b0, "R8 masked flag no irq");

      // R10 wrap and clear of flag B on the same edge
      wr(2'd3, 32'hFFFFFFFF);
      wr(2'd0, 32'h00007021);
      chk_irq(1'b1, "R8 enable raises irq on old flag");
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h00007221;
      evt_in = ev(7);
      @(posedge clk);
      #0.5;
      reg_wr = 1'b0; evt_in = '0;
      wr(2'd0, 32'h00007020);
      chk_rd(2'd0, 32'h00007220, "R10 flag survives clear");
      chk_rd(2'd3, 32'h0, "R10 counter wrapped");
      chk_irq(1'b1, "R10 irq still high");
      wr(2'd0, 32'h00007220);
      chk_irq(1'b0, "R9 irq cleared");

      // R7 cycle counter wrap
      wr(2'd1, 32'hFFFFFFFF);
      wr(2'd0, 32'h41);
      wr(2'd0, 32'h40);
      chk_rd(2'd1, 32'h0, "R7 cycle wrapped");
      chk_rd(2'd0, 32'h440, "R7 cycle flag");
      chk_irq(1'b1, "R8 cycle irq");
      wr(2'd0, 32'h440);
      chk_rd(2'd0, 32'h40, "R9 cycle flag cleared");

      // R11 clear requests
      wr(2'd0, 32'h0);
      wr(2'd1, 32'hCC);
      wr(2'd2, 32'hAA);
      wr(2'd3, 32'hBB);
      wr(2'd0, 32'h2);
      idle(1);
      chk_rd(2'd2, 32'h0, "R11 event A cleared");
      chk_rd(2'd3, 32'h0, "R11 event B cleared");
      chk_rd(2'd1, 32'hCC, "R11 cycle untouched");
      chk_rd(2'd0, 32'h0, "R11 clear bits read zero");
      wr(2'd0, 32'h4);
      idle(1);
      chk_rd(2'd1, 32'h0, "R11 cycle cleared");

      // R12 direct write and pending clear on the same edge
      wr(2'd3, 32'h55);
      wr(2'd0, 32'h2);
      wr(2'd2, 32'h1234);
      chk_rd(2'd2, 32'h1234, "R12 write wins");
      chk_rd(2'd3, 32'h0, "R12 other counter cleared");

      // R13 spare bits
      wr(2'd0, 32'hFFFFFFFF);
      chk_rd(2'd0, 32'h0FFFF079, "R13 spare bits zero");
      chk_irq(1'b0, "R13 no flags after all-ones write");
      wr(2'd0, 32'h0);

      idle(2);
      done = 1'b1;
      report();
   end

endmodule